// File: doc/BRIEF.md
# Speculative Lock Elision Tracker

This block lets one core run a lock-protected critical section without taking the lock. It works alongside that core's L1. Speculation starts when the core has read the lock word, found it free and holds it with shared permission only. From then on the block records, per L1 line, whether the line was read or written speculatively. Speculative store data is held in a small side buffer rather than in the cache, and the core looks that buffer up alongside the L1 on its loads. Incoming coherence requests are checked against the per-line marks. A request that would break isolation aborts the region. On abort the block discards the buffered data, tells the L1 which lines to invalidate and asks for a register restore. The restore covers only the registers the region overwrote, which a lazy checkpoint mask records.

When the region ends cleanly, the block commits. In one cycle it publishes the set of written lines, then hands the buffered lines to the L1 one per cycle. If a store needs a buffer entry and none is free, the block signals that the core must acquire the lock for real. It then commits what it holds, and the core carries on without speculation. A small table of 2-bit saturating counters, indexed by lock address, learns which locks fail often and blocks speculation on them. The pipeline, the register file and the coherence fabric are outside the block and are seen only through its ports.

Top module: `slt_tracker`

## Requirements
- R1: After reset the block is not speculating, raises no pulse, is not draining, and every failure counter is 0, so `spec_ok` is 1 for any lock address.
- R2: `begin_req` starts speculation only when the block is idle, not draining and `spec_ok` is 1. Starting marks `lock_line` as speculatively read, and `spec_active` rises at the next clock edge.
- R3: While speculating, a snoop with `snoop_is_write`=1 to a read-marked line, or any snoop to a write-marked line, is a conflict. A read snoop to a line that is only read-marked is not.
- R4: A conflict makes the block raise `abort_pulse` and `restore_req` together one cycle after the edge that sampled it. In that cycle `inval_lines` holds the written lines, with bit i standing for L1 line i. The block then leaves speculation, and the buffered data is discarded.
- R5: Every commit, fallback and abort clears all read and write marks and the checkpoint mask in a single edge. A later speculation sees none of the earlier marks.
- R6: During speculation, the first write to register i raises `ckpt_save` with `ckpt_idx`=i for one cycle and sets bit i of `ckpt_mask`. Later writes to the same register raise nothing. At abort, `restore_mask` equals `ckpt_mask` as it was before the abort.
- R7: A speculative store to a line whose `st_dirty` is 1 and which is not yet write-marked raises `wb_req` with `wb_line` one cycle later. A store to a clean line, or to a line that is already write-marked, raises no writeback.
- R8: While speculating, `ld_hit` and `ld_data` give the newest buffered data for `ld_line`. Outside speculation `ld_hit` is 0.
- R9: `end_req` during speculation raises `commit_pulse`, with `commit_lines` set to the written lines. From that same cycle the buffered lines appear on `drain_valid`/`drain_line`/`drain_data`, one per cycle, in the order they were first written. No new speculation starts until draining ends.
- R10: A store to a new line when all 32 buffer entries are in use raises `fallback_pulse` and `commit_pulse`. The store is not buffered, and the 32 held entries drain.
- R11: Evicting a line that carries a read or write mark aborts as in R4. Evicting an unmarked line has no effect.
- R12: The failure counter chosen by `lock_addr[3:0]` counts up, saturating at 3, on each abort or fallback. It counts down, saturating at 0, on each clean commit. `spec_ok` is 1 only while that counter is below 2.
- R13: Within one cycle an abort takes precedence over `end_req`, and `end_req` takes precedence over a fallback. Loads, stores and register writes in such a cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_addr | input | 32 | Address of the lock word being elided |
| lock_line | input | 6 | L1 line holding the lock word |
| begin_req | input | 1 | Request to enter speculation (lock read as free) |
| end_req | input | 1 | Critical section finished |
| spec_ok | output | 1 | Failure history allows speculation on `lock_addr` |
| spec_active | output | 1 | Speculation in progress |
| ld_valid | input | 1 | Core load to `ld_line` (marks it read) |
| ld_line | input | 6 | Load line index, also the side-buffer lookup key |
| ld_hit | output | 1 | Side buffer holds `ld_line` |
| ld_data | output | 512 | Buffered line data |
| st_valid | input | 1 | Core store of a full line |
| st_line | input | 6 | Store line index |
| st_data | input | 512 | Store line data |
| st_dirty | input | 1 | L1 copy of `st_line` is dirty |
| wb_req | output | 1 | Write back `wb_line` before its speculative update |
| wb_line | output | 6 | Line to write back |
| reg_wr_valid | input | 1 | Core register write |
| reg_wr_idx | input | 5 | Register written |
| ckpt_save | output | 1 | Save the old value of `ckpt_idx` |
| ckpt_idx | output | 5 | Register to save |
| ckpt_mask | output | 32 | Registers saved in this region |
| snoop_valid | input | 1 | Incoming coherence request |
| snoop_line | input | 6 | Line the request targets |
| snoop_is_write | input | 1 | Request asks for write permission |
| evict_valid | input | 1 | L1 is evicting a line |
| evict_line | input | 6 | Evicted line |
| commit_pulse | output | 1 | Buffered writes become visible |
| abort_pulse | output | 1 | Speculation abandoned |
| fallback_pulse | output | 1 | Acquire the lock for real |
| restore_req | output | 1 | Reload the checkpointed registers |
| restore_mask | output | 32 | Registers to reload |
| inval_lines | output | 64 | Lines to invalidate on abort |
| commit_lines | output | 64 | Lines published on commit |
| drain_valid | output | 1 | A committed line is presented |
| drain_line | output | 6 | Committed line index |
| drain_data | output | 512 | Committed line data |

## Verification
The bench drives a run of speculative regions that hit the following corner cases:
- **Read snoop on the lock line.** Treating read against read as a conflict would abort the region.
- **Write snoop on a line marked by an earlier region.** A design without flash clear would abort on it.
- **Repeated stores to a dirty line.** A design that ignores the write mark would request a writeback on every store.
- **The 33rd distinct store line.** A design that sized the buffer wrongly would report fallback too early or too late, or would drain the wrong number of entries.
- **Same-cycle collisions.** An abort arriving with `end_req`, or a store arriving with `end_req`, shows whether the design commits stale data or buffers a store it should drop.
- **Lock suppression.** Two aborts on one lock must suppress speculation on it while another lock stays usable. A design without saturation or with the wrong index would get this wrong.

// File: rtl/slt_pkg.sv
// Shared definitions for the speculative lock elision tracker.
package slt_pkg;
    // Control state of the tracker; draining is held by the side buffer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SPEC = 1'b1
    } slt_state_e;

    // Width of each per-lock failure counter and the suppression threshold.
    localparam int HIST_CTR_W = 2;
    localparam int HIST_LIMIT = 2;
endpackage

// File: rtl/slt_line_marks.sv
// Per-line speculative read/write marks with flash clear.
// Assumes at most one read-mark and one write-mark set per cycle and that
// the caller gates snoop and eviction checking with watch_en.
module slt_line_marks #(
    parameter int LINES = 64,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash_clr,
    input  logic             rset_en,
    input  logic [LW-1:0]    rset_idx,
    input  logic             wset_en,
    input  logic [LW-1:0]    wset_idx,
    input  logic             watch_en,
    input  logic             snoop_valid,
    input  logic [LW-1:0]    snoop_line,
    input  logic             snoop_is_write,
    input  logic             evict_valid,
    input  logic [LW-1:0]    evict_line,
    output logic             conflict,
    output logic             evict_hit,
    output logic [LINES-1:0] wr_lines
);
    logic [LINES-1:0] rd_mark;
    logic [LINES-1:0] wr_mark;

    // Set marks as the region touches lines; clear all in one edge at region end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mark <= '0;
            wr_mark <= '0;
        end else if (flash_clr) begin
            rd_mark <= '0;
            wr_mark <= '0;
        end else begin
            if (rset_en) rd_mark[rset_idx] <= 1'b1;
            if (wset_en) wr_mark[wset_idx] <= 1'b1;
        end
    end

    // Conflict: write hits any mark, read hits a write mark.
    always_comb begin
        conflict  = watch_en && snoop_valid &&
                    (wr_mark[snoop_line] || (snoop_is_write && rd_mark[snoop_line]));
        evict_hit = watch_en && evict_valid &&
                    (rd_mark[evict_line] || wr_mark[evict_line]);
    end

    assign wr_lines = wr_mark;
endmodule

// File: rtl/slt_side_buf.sv
// Side buffer holding speculative line data, filled in first-write order.
// Looked up in parallel by line index; drains one entry per cycle after a
// commit. Assumes flush and drain_start never arrive while draining.
module slt_side_buf #(
    parameter int DEPTH = 32,
    parameter int LW    = 6,
    parameter int DW    = 512,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          st_en,
    input  logic [LW-1:0] st_line,
    input  logic [DW-1:0] st_data,
    output logic          st_full_miss,
    input  logic [LW-1:0] lk_line,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    input  logic          drain_start,
    output logic          drain_valid,
    output logic [LW-1:0] drain_line,
    output logic [DW-1:0] drain_data
);
    logic [LW-1:0]    ent_line [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [CW-1:0]    count;
    logic [IW-1:0]    ptr;
    logic             draining;
    logic [DEPTH-1:0] st_match;
    logic [DEPTH-1:0] lk_match;
    logic [IW-1:0]    st_idx;
    logic             st_hit;
    logic             full;

    // One comparator pair per entry; only occupied entries take part.
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            logic occupied;
            assign occupied    = CW'(g) < count;
            assign st_match[g] = occupied && (ent_line[g] == st_line);
            assign lk_match[g] = occupied && (ent_line[g] == lk_line);
        end
    endgenerate

    // Encode the store match and select lookup data.
    always_comb begin
        st_idx  = '0;
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_match[i]) st_idx = IW'(i);
            if (lk_match[i]) lk_data = ent_data[i];
        end
        st_hit       = |st_match;
        lk_hit       = |lk_match;
        full         = (count == CW'(DEPTH));
        st_full_miss = !st_hit && full;
    end

    // Write store data: overwrite a matching entry or append a new one.
    always_ff @(posedge clk) begin
        if (st_en) begin
            if (st_hit) begin
                ent_data[st_idx] <= st_data;
            end else if (!full) begin
                ent_line[IW'(count)] <= st_line;
                ent_data[IW'(count)] <= st_data;
            end
        end
    end

    // Occupancy and drain sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            ptr      <= '0;
            draining <= 1'b0;
        end else if (flush) begin
            count <= '0;
        end else if (drain_start) begin
            ptr      <= '0;
            draining <= (count != '0);
        end else if (draining) begin
            if (CW'(ptr) == count - CW'(1)) begin
                draining <= 1'b0;
                count    <= '0;
                ptr      <= '0;
            end else begin
                ptr <= ptr + IW'(1);
            end
        end else if (st_en && !st_hit && !full) begin
            count <= count + CW'(1);
        end
    end

    assign drain_valid = draining;
    assign drain_line  = ent_line[ptr];
    assign drain_data  = ent_data[ptr];
endmodule

// File: rtl/slt_lock_hist.sv
// Direct-mapped table of saturating failure counters indexed by lock address
// low bits. Assumes aliasing between locks sharing an index is acceptable.
module slt_lock_hist #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int HW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] q_addr,
    output logic          q_ok,
    output logic [HW-1:0] q_idx,
    input  logic          upd_en,
    input  logic [HW-1:0] upd_idx,
    input  logic          upd_inc
);
    import slt_pkg::*;
    localparam logic [HIST_CTR_W-1:0] CTR_MAX = '1;

    logic [HIST_CTR_W-1:0] ctr [DEPTH];

    // Query the counter of the presented lock.
    always_comb begin
        q_idx = q_addr[HW-1:0];
        q_ok  = ctr[q_idx] < HIST_CTR_W'(HIST_LIMIT);
    end

    // Count failures up and successes down, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= '0;
        end else if (upd_en) begin
            if (upd_inc && ctr[upd_idx] != CTR_MAX)
                ctr[upd_idx] <= ctr[upd_idx] + HIST_CTR_W'(1);
            else if (!upd_inc && ctr[upd_idx] != '0)
                ctr[upd_idx] <= ctr[upd_idx] - HIST_CTR_W'(1);
        end
    end
endmodule

// File: rtl/slt_reg_ckpt.sv
// Lazy register checkpoint mask: requests a save on the first write to each
// register in a region. Assumes clr is raised at every region end.
module slt_reg_ckpt #(
    parameter int NREGS = 32,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_idx,
    output logic             save_o,
    output logic [RW-1:0]    save_idx,
    output logic [NREGS-1:0] mask
);
    // Record first writes and pulse a save request for each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            save_o   <= 1'b0;
            save_idx <= '0;
        end else begin
            save_o   <= 1'b0;
            save_idx <= '0;
            if (clr) begin
                mask <= '0;
            end else if (wr_en && !mask[wr_idx]) begin
                mask[wr_idx] <= 1'b1;
                save_o       <= 1'b1;
                save_idx     <= wr_idx;
            end
        end
    end
endmodule

// File: rtl/slt_tracker.sv
// Speculative lock elision tracker for one core's L1.
// Decides region start, commit, fallback and abort, with the priority
// abort > end > fallback > ordinary accesses. Result pulses are registered and
// appear one cycle after the edge that sampled their cause. Assumes the core
// raises begin_req only after reading the lock word as free.
module slt_tracker #(
    parameter int LINES      = 64,
    parameter int SB_DEPTH   = 32,
    parameter int LINE_BYTES = 64,
    parameter int LOCK_AW    = 32,
    parameter int HIST_DEPTH = 16,
    parameter int NREGS      = 32,
    localparam int LW = $clog2(LINES),
    localparam int DW = LINE_BYTES * 8,
    localparam int RW = $clog2(NREGS),
    localparam int HW = $clog2(HIST_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LOCK_AW-1:0] lock_addr,
    input  logic [LW-1:0]      lock_line,
    input  logic               begin_req,
    input  logic               end_req,
    output logic               spec_ok,
    output logic               spec_active,
    input  logic               ld_valid,
    input  logic [LW-1:0]      ld_line,
    output logic               ld_hit,
    output logic [DW-1:0]      ld_data,
    input  logic               st_valid,
    input  logic [LW-1:0]      st_line,
    input  logic [DW-1:0]      st_data,
    input  logic               st_dirty,
    output logic               wb_req,
    output logic [LW-1:0]      wb_line,
    input  logic               reg_wr_valid,
    input  logic [RW-1:0]      reg_wr_idx,
    output logic               ckpt_save,
    output logic [RW-1:0]      ckpt_idx,
    output logic [NREGS-1:0]   ckpt_mask,
    input  logic               snoop_valid,
    input  logic [LW-1:0]      snoop_line,
    input  logic               snoop_is_write,
    input  logic               evict_valid,
    input  logic [LW-1:0]      evict_line,
    output logic               commit_pulse,
    output logic               abort_pulse,
    output logic               fallback_pulse,
    output logic               restore_req,
    output logic [NREGS-1:0]   restore_mask,
    output logic [LINES-1:0]   inval_lines,
    output logic [LINES-1:0]   commit_lines,
    output logic               drain_valid,
    output logic [LW-1:0]      drain_line,
    output logic [DW-1:0]      drain_data
);
    import slt_pkg::*;

    slt_state_e       state;
    logic [HW-1:0]    hidx_q;
    logic [HW-1:0]    q_idx;
    logic             in_spec, go, abort_ev, commit_ev, fall_ev, norm, ending;
    logic             conflict, evict_hit, sb_full_miss, lk_hit;
    logic [LINES-1:0] wr_lines;

    // Event decode with fixed priority.
    always_comb begin
        in_spec   = (state == ST_SPEC);
        go        = (state == ST_IDLE) && !drain_valid && begin_req && spec_ok;
        abort_ev  = in_spec && (conflict || evict_hit);
        commit_ev = in_spec && !abort_ev && end_req;
        fall_ev   = in_spec && !abort_ev && !end_req && st_valid && sb_full_miss;
        norm      = in_spec && !abort_ev && !end_req && !fall_ev;
        ending    = abort_ev || commit_ev || fall_ev;
    end

    slt_line_marks #(.LINES(LINES)) u_marks (
        .clk           (clk),
        .rst_n         (rst_n),
        .flash_clr     (ending),
        .rset_en       (go || (norm && ld_valid)),
        .rset_idx      (go ? lock_line : ld_line),
        .wset_en       (norm && st_valid),
        .wset_idx      (st_line),
        .watch_en      (in_spec),
        .snoop_valid   (snoop_valid),
        .snoop_line    (snoop_line),
        .snoop_is_write(snoop_is_write),
        .evict_valid   (evict_valid),
        .evict_line    (evict_line),
        .conflict      (conflict),
        .evict_hit     (evict_hit),
        .wr_lines      (wr_lines)
    );

    slt_side_buf #(.DEPTH(SB_DEPTH), .LW(LW), .DW(DW)) u_sbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (abort_ev),
        .st_en       (norm && st_valid),
        .st_line     (st_line),
        .st_data     (st_data),
        .st_full_miss(sb_full_miss),
        .lk_line     (ld_line),
        .lk_hit      (lk_hit),
        .lk_data     (ld_data),
        .drain_start (commit_ev || fall_ev),
        .drain_valid (drain_valid),
        .drain_line  (drain_line),
        .drain_data  (drain_data)
    );

    slt_lock_hist #(.DEPTH(HIST_DEPTH), .AW(LOCK_AW)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .q_addr (lock_addr),
        .q_ok   (spec_ok),
        .q_idx  (q_idx),
        .upd_en (ending),
        .upd_idx(hidx_q),
        .upd_inc(abort_ev || fall_ev)
    );

    slt_reg_ckpt #(.NREGS(NREGS)) u_ckpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ending),
        .wr_en   (norm && reg_wr_valid),
        .wr_idx  (reg_wr_idx),
        .save_o  (ckpt_save),
        .save_idx(ckpt_idx),
        .mask    (ckpt_mask)
    );

    // Region state and the history slot of the elided lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hidx_q <= '0;
        end else if (go) begin
            state  <= ST_SPEC;
            hidx_q <= q_idx;
        end else if (ending) begin
            state <= ST_IDLE;
        end
    end

    // Registered result pulses and their line/register vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_pulse   <= 1'b0;
            abort_pulse    <= 1'b0;
            fallback_pulse <= 1'b0;
            restore_req    <= 1'b0;
            restore_mask   <= '0;
            inval_lines    <= '0;
            commit_lines   <= '0;
            wb_req         <= 1'b0;
            wb_line        <= '0;
        end else begin
            commit_pulse   <= commit_ev || fall_ev;
            abort_pulse    <= abort_ev;
            fallback_pulse <= fall_ev;
            restore_req    <= abort_ev;
            restore_mask   <= abort_ev ? ckpt_mask : '0;
            inval_lines    <= abort_ev ? wr_lines : '0;
            commit_lines   <= (commit_ev || fall_ev) ? wr_lines : '0;
            wb_req         <= norm && st_valid && st_dirty && !wr_lines[st_line];
            wb_line        <= (norm && st_valid && st_dirty && !wr_lines[st_line])
                              ? st_line : '0;
        end
    end

    assign spec_active = in_spec;
    assign ld_hit      = lk_hit && in_spec;
endmodule

// File: rtl/slt_tracker_chk.sv
// Temporal checks on the tracker's outputs, attached by bind.
module slt_tracker_chk #(
    parameter int NREGS = 32,
    localparam int RW   = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spec_active,
    input logic             commit_pulse,
    input logic             abort_pulse,
    input logic             fallback_pulse,
    input logic             restore_req,
    input logic             ckpt_save,
    input logic [RW-1:0]    ckpt_idx,
    input logic [NREGS-1:0] ckpt_mask,
    input logic             wb_req,
    input logic             drain_valid,
    input logic             ld_hit
);
    p_abort_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> restore_req && !spec_active);
    p_restore_only_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> abort_pulse);
    p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_pulse, abort_pulse}));
    p_fallback_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_pulse |-> commit_pulse);
    p_ckpt_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> ckpt_mask[ckpt_idx]);
    p_flash_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pulse || abort_pulse) |-> (ckpt_mask == '0));
    p_drain_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> !spec_active);
    p_wb_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> spec_active);
    p_ldhit_no_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> !drain_valid);
endmodule

bind slt_tracker slt_tracker_chk #(.NREGS(NREGS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spec_active   (spec_active),
    .commit_pulse  (commit_pulse),
    .abort_pulse   (abort_pulse),
    .fallback_pulse(fallback_pulse),
    .restore_req   (restore_req),
    .ckpt_save     (ckpt_save),
    .ckpt_idx      (ckpt_idx),
    .ckpt_mask     (ckpt_mask),
    .wb_req        (wb_req),
    .drain_valid   (drain_valid),
    .ld_hit        (ld_hit)
);

// File: tb/tb_slt_tracker.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock plus directed checks.
module tb_slt_tracker;
    localparam int LINES = 64, SB = 32, DW = 512, NREGS = 32, LW = 6, RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] lock_addr = '0;
    logic [LW-1:0] lock_line = '0, ld_line = '0, st_line = '0, snoop_line = '0, evict_line = '0;
    logic begin_req = 0, end_req = 0, ld_valid = 0, st_valid = 0, st_dirty = 0;
    logic reg_wr_valid = 0, snoop_valid = 0, snoop_is_write = 0, evict_valid = 0;
    logic [RW-1:0] reg_wr_idx = '0;
    logic [DW-1:0] st_data = '0;

    logic spec_ok, spec_active, ld_hit, wb_req, ckpt_save, commit_pulse, abort_pulse;
    logic fallback_pulse, restore_req, drain_valid;
    logic [DW-1:0] ld_data, drain_data;
    logic [LW-1:0] wb_line, drain_line;
    logic [RW-1:0] ckpt_idx;
    logic [NREGS-1:0] ckpt_mask, restore_mask;
    logic [LINES-1:0] inval_lines, commit_lines;

    slt_tracker dut (
        .clk(clk), .rst_n(rst_n), .lock_addr(lock_addr), .lock_line(lock_line),
        .begin_req(begin_req), .end_req(end_req), .spec_ok(spec_ok), .spec_active(spec_active),
        .ld_valid(ld_valid), .ld_line(ld_line), .ld_hit(ld_hit), .ld_data(ld_data),
        .st_valid(st_valid), .st_line(st_line), .st_data(st_data), .st_dirty(st_dirty),
        .wb_req(wb_req), .wb_line(wb_line), .reg_wr_valid(reg_wr_valid), .reg_wr_idx(reg_wr_idx),
        .ckpt_save(ckpt_save), .ckpt_idx(ckpt_idx), .ckpt_mask(ckpt_mask),
        .snoop_valid(snoop_valid), .snoop_line(snoop_line), .snoop_is_write(snoop_is_write),
        .evict_valid(evict_valid), .evict_line(evict_line), .commit_pulse(commit_pulse),
        .abort_pulse(abort_pulse), .fallback_pulse(fallback_pulse), .restore_req(restore_req),
        .restore_mask(restore_mask), .inval_lines(inval_lines), .commit_lines(commit_lines),
        .drain_valid(drain_valid), .drain_line(drain_line), .drain_data(drain_data)
    );

    int vecs = 0;
    int errs = 0;

    // Reference model state
    bit m_active, m_drain;
    int m_dptr, m_hidx;
    int mq_line[$];
    logic [DW-1:0] mq_data[$];
    logic [LINES-1:0] m_r, m_w, m_inval, m_clines;
    logic [NREGS-1:0] m_mask, m_rmask;
    int m_hist[16];
    bit m_commit, m_abort, m_fall, m_rest, m_wb, m_ck;
    int m_wbline, m_ckidx;

    function automatic logic [DW-1:0] pat(int line, int k);
        return {16{32'(line * 1000 + k)}};
    endfunction

    function automatic int find(int line);
        foreach (mq_line[i]) if (mq_line[i] == line) return i;
        return -1;
    endfunction

    task automatic model_reset();
        m_active = 0; m_drain = 0; m_dptr = 0; m_hidx = 0;
        mq_line.delete(); mq_data.delete();
        m_r = '0; m_w = '0; m_mask = '0;
        foreach (m_hist[i]) m_hist[i] = 0;
        m_commit = 0; m_abort = 0; m_fall = 0; m_rest = 0; m_wb = 0; m_ck = 0;
        m_rmask = '0; m_inval = '0; m_clines = '0; m_wbline = 0; m_ckidx = 0;
    endtask

    task automatic model_end();
        m_r = '0; m_w = '0; m_mask = '0; m_active = 0;
    endtask

    task automatic model_step();
        bit conf, ev, ovf;
        int ix;
        m_commit = 0; m_abort = 0; m_fall = 0; m_rest = 0; m_wb = 0; m_ck = 0;
        m_rmask = '0; m_inval = '0; m_clines = '0; m_wbline = 0; m_ckidx = 0;
        if (m_drain) begin
            m_dptr++;
            if (m_dptr == mq_line.size()) begin
                m_drain = 0; m_dptr = 0; mq_line.delete(); mq_data.delete();
            end
        end else if (!m_active) begin
            if (begin_req && m_hist[lock_addr[3:0]] < 2) begin
                m_active = 1; m_r[lock_line] = 1'b1; m_hidx = int'(lock_addr[3:0]);
            end
        end else begin
            conf = snoop_valid && (m_w[snoop_line] || (snoop_is_write && m_r[snoop_line]));
            ev   = evict_valid && (m_r[evict_line] || m_w[evict_line]);
            ovf  = st_valid && find(int'(st_line)) < 0 && mq_line.size() == SB;
            if (conf || ev) begin
                m_abort = 1; m_rest = 1; m_rmask = m_mask; m_inval = m_w;
                mq_line.delete(); mq_data.delete();
                if (m_hist[m_hidx] < 3) m_hist[m_hidx]++;
                model_end();
            end else if (end_req || ovf) begin
                m_commit = 1; m_fall = !end_req; m_clines = m_w;
                if (end_req) begin
                    if (m_hist[m_hidx] > 0) m_hist[m_hidx]--;
                end else if (m_hist[m_hidx] < 3) m_hist[m_hidx]++;
                if (mq_line.size() > 0) begin m_drain = 1; m_dptr = 0; end
                model_end();
            end else begin
                if (ld_valid) m_r[ld_line] = 1'b1;
                if (st_valid) begin
                    if (st_dirty && !m_w[st_line]) begin m_wb = 1; m_wbline = int'(st_line); end
                    m_w[st_line] = 1'b1;
                    ix = find(int'(st_line));
                    if (ix >= 0) mq_data[ix] = st_data;
                    else begin mq_line.push_back(int'(st_line)); mq_data.push_back(st_data); end
                end
                if (reg_wr_valid && !m_mask[reg_wr_idx]) begin
                    m_mask[reg_wr_idx] = 1'b1; m_ck = 1; m_ckidx = int'(reg_wr_idx);
                end
            end
        end
    endtask

    task automatic cmp(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk(bit cond, string msg);
        vecs++;
        if (!cond) begin
            errs++;
            $display("FAIL %s actual=0 expected=1", msg);
        end
    endtask

    task automatic check_all();
        int ix;
        ix = find(int'(ld_line));
        cmp("R2 spec_active", DW'(spec_active), DW'(m_active));
        cmp("R12 spec_ok", DW'(spec_ok), DW'(m_hist[lock_addr[3:0]] < 2));
        cmp("R9 commit_pulse", DW'(commit_pulse), DW'(m_commit));
        cmp("R4 abort_pulse", DW'(abort_pulse), DW'(m_abort));
        cmp("R10 fallback_pulse", DW'(fallback_pulse), DW'(m_fall));
        cmp("R4 restore_req", DW'(restore_req), DW'(m_rest));
        cmp("R6 restore_mask", DW'(restore_mask), DW'(m_rmask));
        cmp("R4 inval_lines", DW'(inval_lines), DW'(m_inval));
        cmp("R9 commit_lines", DW'(commit_lines), DW'(m_clines));
        cmp("R7 wb_req", DW'(wb_req), DW'(m_wb));
        cmp("R7 wb_line", DW'(wb_line), DW'(m_wbline));
        cmp("R6 ckpt_save", DW'(ckpt_save), DW'(m_ck));
        cmp("R6 ckpt_idx", DW'(ckpt_idx), DW'(m_ckidx));
        cmp("R6 ckpt_mask", DW'(ckpt_mask), DW'(m_mask));
        cmp("R8 ld_hit", DW'(ld_hit), DW'(m_active && ix >= 0));
        if (m_active && ix >= 0) cmp("R8 ld_data", ld_data, mq_data[ix]);
        cmp("R9 drain_valid", DW'(drain_valid), DW'(m_drain));
        if (m_drain) begin
            cmp("R9 drain_line", DW'(drain_line), DW'(mq_line[m_dptr]));
            cmp("R9 drain_data", drain_data, mq_data[m_dptr]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic start(logic [31:0] a, logic [LW-1:0] l);
        lock_addr = a; lock_line = l; begin_req = 1; tick(); begin_req = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all();
        chk(spec_ok && !spec_active && !drain_valid && !commit_pulse, "R1 reset state");
        rst_n = 1;

        // Clean region: marks, writebacks, checkpoint, lookup, commit and drain
        start(32'h100, 6'd5);
        chk(spec_active, "R2 begin accepted");
        ld_valid = 1; ld_line = 6'd1; tick(); ld_line = 6'd2; tick(); ld_valid = 0;
        snoop_valid = 1; snoop_line = 6'd5; snoop_is_write = 0; tick(); snoop_valid = 0;
        chk(spec_active && !abort_pulse, "R3 read snoop on read-marked line ignored");
        st_valid = 1; st_line = 6'd10; st_dirty = 1; st_data = pat(10, 0); tick();
        chk(wb_req && wb_line == 6'd10, "R7 first store to dirty line writes back");
        st_data = pat(10, 1); tick();
        chk(!wb_req, "R7 repeat store no writeback");
        st_line = 6'd11; st_dirty = 0; st_data = pat(11, 0); tick(); st_valid = 0;
        reg_wr_valid = 1; reg_wr_idx = 5'd3; tick();
        chk(ckpt_save && ckpt_idx == 5'd3, "R6 first register write saved");
        tick();
        chk(!ckpt_save, "R6 second write not saved");
        reg_wr_idx = 5'd7; tick(); reg_wr_valid = 0;
        ld_line = 6'd10; tick();
        chk(ld_hit && ld_data == pat(10, 1), "R8 lookup returns newest data");
        end_req = 1; tick(); end_req = 0;
        chk(commit_pulse && commit_lines == ((64'd1 << 10) | (64'd1 << 11)), "R9 commit lines");
        chk(drain_valid && drain_line == 6'd10, "R9 first drained line");
        begin_req = 1; tick(); begin_req = 0;
        chk(drain_line == 6'd11 && !spec_active, "R9 begin refused while draining");
        tick();
        chk(!drain_valid && !ld_hit, "R8 no lookup hit outside speculation");

        // Flash clear, then a conflicting read snoop on a written line
        start(32'h100, 6'd5);
        snoop_valid = 1; snoop_line = 6'd1; snoop_is_write = 1; tick(); snoop_valid = 0;
        chk(spec_active && !abort_pulse, "R5 old marks cleared");
        st_valid = 1; st_line = 6'd12; st_dirty = 0; st_data = pat(12, 0); tick(); st_valid = 0;
        reg_wr_valid = 1; reg_wr_idx = 5'd4; tick(); reg_wr_valid = 0;
        snoop_valid = 1; snoop_line = 6'd12; snoop_is_write = 0; tick(); snoop_valid = 0;
        chk(abort_pulse && restore_req && inval_lines == (64'd1 << 12) &&
            restore_mask == (32'd1 << 4), "R3 read snoop on written line aborts");
        ld_line = 6'd12; tick();
        chk(!ld_hit && !spec_active, "R4 buffer discarded");

        // Eviction
        start(32'h100, 6'd5);
        evict_valid = 1; evict_line = 6'd30; tick();
        chk(spec_active, "R11 unmarked eviction ignored");
        evict_line = 6'd5; tick(); evict_valid = 0;
        chk(abort_pulse, "R11 marked eviction aborts");

        // History suppression
        tick();
        chk(!spec_ok, "R12 lock suppressed after two failures");
        start(32'h100, 6'd5);
        chk(!spec_active, "R12 begin refused");

        // Overflow fallback
        start(32'h101, 6'd6);
        chk(spec_ok && spec_active, "R12 other lock unaffected");
        st_valid = 1; st_dirty = 0;
        for (int i = 0; i < SB; i++) begin
            st_line = LW'(20 + i); st_data = pat(20 + i, 2); tick();
        end
        st_line = 6'd52; st_data = pat(52, 2); tick(); st_valid = 0;
        chk(fallback_pulse && commit_pulse && drain_line == 6'd20, "R10 fallback on full buffer");
        for (int k = 1; k < SB; k++) begin
            tick();
            chk(drain_valid && drain_line == LW'(20 + k), "R10 drain order");
        end
        tick();
        chk(!drain_valid, "R10 overflowing store not buffered");

        // Same-cycle priority
        start(32'h102, 6'd7);
        snoop_valid = 1; snoop_line = 6'd7; snoop_is_write = 1; end_req = 1; tick();
        snoop_valid = 0; end_req = 0;
        chk(abort_pulse && !commit_pulse, "R13 abort beats end");
        start(32'h103, 6'd8);
        end_req = 1; st_valid = 1; st_line = 6'd40; st_data = pat(40, 3);
        reg_wr_valid = 1; reg_wr_idx = 5'd9; tick();
        end_req = 0; st_valid = 0; reg_wr_valid = 0;
        chk(commit_pulse && commit_lines == '0 && !drain_valid && !ckpt_save, "R13 store dropped at end");
        repeat (3) tick();
        summary();
    end
endmodule